// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block controls a successive-approximation analog-to-digital converter beside a small processor core. Software writes two control registers: enable, a start/busy flag, channel, conversion clock, result alignment and port configuration. Setting the start flag launches a conversion. The block waits one cycle, then resolves a 10-bit code from the most significant bit down, one bit per conversion-clock period. It drives a trial code to an external DAC and reads back one comparator bit. A two-period settling wait follows. The block then stores the result, clears the busy flag and raises a completion flag.

A sleep input changes what happens to a conversion in flight. With a divided system clock selected, sleep aborts the conversion. With the self-timed clock selected, the conversion runs to the end. The block then either raises a wake request or leaves the converter powered down.

The register port has four byte addresses:

| Address | Contents |
|---|---|
| 0 | `{channel[3:0], clock select[1:0], busy, enable}` |
| 1 | `{align, done flag, 2'b00, port config[3:0]}` |
| 2 | result high byte |
| 3 | result low byte |

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, addresses 0 and 1 read 0, `adc_pwr` is 0 and `wake_req` is 0.
- R2: While the enable bit (address 0, bit 0) is 0, the busy flag (bit 1) reads 0, a write that sets it has no effect, and `adc_pwr` is 0.
- R3: A write of enable=1 and busy=1 starts the conversion one cycle after the write edge. The busy flag reads 0 exactly 1+12·P clock edges after the write edge, where P is the conversion-clock period. That is one delay cycle, 10 bit periods and 2 tail periods. `dac_code` is 0 during the delay cycle.
- R4: Bits are resolved from MSB to LSB. On each bit period the trial bit is set on `dac_code`, and it is kept when `cmp_in` is 1. The final code therefore equals the input level seen by the comparator.
- R5: On completion the busy flag clears, the done flag (address 1, bit 6) becomes 1 and the result registers update. The result changes at no other time. Software writes address 1 bit 6 to clear the done flag.
- R6: Clock select (address 0, bits 3:2) gives P = 2, 8 or 32 for the values 0, 1 and 2. The value 3 selects the self-timed clock, with P = `RC_DIV` (default 4).
- R7: If `sleep_req` is 1 during a conversion with clock select 0 to 2, the busy flag clears on the next edge. The done flag stays 0, the result is unchanged, `wake_req` stays 0 and `adc_pwr` drops.
- R8: With clock select 3, a conversion continues through sleep and completes normally. If `wake_en` is 1 at completion, `wake_req` rises and holds until `sleep_req` falls. Otherwise `wake_req` stays 0 and `adc_pwr` is 0 while sleeping. `adc_pwr` is 1 while the conversion runs in sleep.
- R9: When the align bit (address 1, bit 7) is 1, the result is right-justified: high byte `{6'b0, r[9:8]}`, low byte `r[7:0]`. When it is 0, the result is left-justified: high byte `r[9:2]`, low byte `{r[1:0], 6'b0}`.
- R10: A software write that clears the busy flag or the enable bit aborts a running conversion. The done flag stays 0 and the result is unchanged.
- R11: `chan_sel` always presents the channel field, and `port_cfg` presents the port configuration field, which reads back at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (instruction) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sleep_req | input | 1 | Core is in sleep |
| wake_en | input | 1 | Completion may wake the core |
| cmp_in | input | 1 | Comparator: input level ≥ DAC code |
| chan_sel | output | 4 | Channel to acquire |
| port_cfg | output | 4 | Analog/digital port configuration |
| dac_code | output | 10 | Trial code to the DAC |
| adc_pwr | output | 1 | Converter power enable |
| wake_req | output | 1 | Wake request after a sleep conversion |

## Verification
The bound assertions check these rules on every cycle:
- busy is never set while the block is disabled;
- the done flag rises and the result changes only when busy falls;
- a sleep with a divided clock ends busy on the next edge;
- the wake request rises only after sleep with wake enabled;
- the trial code is 0 in the start delay cycle.

Only the bench scenarios can show the rest: the exact conversion length for each clock choice, that the resolved code matches the comparator's input level, both result alignments, and that an abort leaves the old result intact.

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES    = 10,
  parameter int RC_DIV = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           sleep_req,
  input  logic           wake_en,
  input  logic           cmp_in,
  output logic [3:0]     chan_sel,
  output logic [3:0]     port_cfg,
  output logic [RES-1:0] dac_code,
  output logic           adc_pwr,
  output logic           wake_req
);
  localparam int BW   = $clog2(RES);
  localparam int DMAX = (RC_DIV > 32) ? RC_DIV : 32;
  localparam int DW   = $clog2(DMAX) + 1;

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_CONV, S_TAIL} st_t;

  st_t            st_q;
  logic           en_q, go_q, just_q, irq_q, wake_q, tail_q;
  logic [3:0]     chan_q, pcfg_q;
  logic [1:0]     cks_q;
  logic [RES-1:0] code_q, res_q;
  logic [BW-1:0]  bit_q;
  logic [DW-1:0]  tdiv_q, per;
  logic [15:0]    rpair;

  always_comb begin
    case (cks_q)
      2'd0:    per = DW'(2);
      2'd1:    per = DW'(8);
      2'd2:    per = DW'(32);
      default: per = DW'(RC_DIV);
    endcase
  end

  wire tick     = (tdiv_q == per - 1'b1);
  wire wr0      = reg_we && (reg_addr == 2'd0);
  wire wr1      = reg_we && (reg_addr == 2'd1);
  wire start    = wr0 && reg_wdata[0] && reg_wdata[1] && !go_q && !sleep_req;
  wire sw_abort = wr0 && go_q && !(reg_wdata[0] && reg_wdata[1]);
  wire sl_abort = go_q && sleep_req && (cks_q != 2'd3);
  wire abort    = sw_abort || sl_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      just_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      tail_q <= 1'b0;
      chan_q <= '0;
      pcfg_q <= '0;
      cks_q  <= '0;
      code_q <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      tdiv_q <= '0;
    end else begin
      if (wr0) begin
        en_q   <= reg_wdata[0];
        cks_q  <= reg_wdata[3:2];
        chan_q <= reg_wdata[7:4];
      end
      if (wr1) begin
        pcfg_q <= reg_wdata[3:0];
        irq_q  <= reg_wdata[6];
        just_q <= reg_wdata[7];
      end
      if (!sleep_req) wake_q <= 1'b0;
      if (st_q == S_DLY || tick) tdiv_q <= '0;
      else                       tdiv_q <= tdiv_q + 1'b1;

      if (abort) begin
        st_q   <= S_IDLE;
        go_q   <= 1'b0;
        code_q <= '0;
      end else begin
        case (st_q)
          S_IDLE: if (start) begin
            go_q <= 1'b1;
            st_q <= S_DLY;
          end
          S_DLY: begin
            st_q   <= S_CONV;
            code_q <= RES'(1) << (RES - 1);
            bit_q  <= BW'(RES - 1);
          end
          S_CONV: if (tick) begin
            code_q[bit_q] <= cmp_in;
            if (bit_q != '0) begin
              code_q[bit_q - 1'b1] <= 1'b1;
              bit_q <= bit_q - 1'b1;
            end else begin
              st_q   <= S_TAIL;
              tail_q <= 1'b0;
            end
          end
          default: if (tick) begin
            tail_q <= 1'b1;
            if (tail_q) begin
              st_q   <= S_IDLE;
              go_q   <= 1'b0;
              irq_q  <= 1'b1;
              res_q  <= code_q;
              code_q <= '0;
              if (sleep_req && wake_en) wake_q <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign rpair = just_q ? 16'(res_q) : {res_q, {(16 - RES){1'b0}}};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {chan_q, cks_q, go_q, en_q};
      2'd1:    reg_rdata = {just_q, irq_q, 2'b00, pcfg_q};
      2'd2:    reg_rdata = rpair[15:8];
      default: reg_rdata = rpair[7:0];
    endcase
  end

  assign chan_sel = chan_q;
  assign port_cfg = pcfg_q;
  assign dac_code = code_q;
  assign adc_pwr  = en_q && (!sleep_req || go_q);
  assign wake_req = wake_q;
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [1:0]     reg_addr,
  input logic           sleep_req,
  input logic           wake_en,
  input logic           en_q,
  input logic           go_q,
  input logic           irq_q,
  input logic           wake_q,
  input logic [1:0]     cks_q,
  input logic [RES-1:0] res_q,
  input logic [RES-1:0] dac_code
);
  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !go_q); // R2
  AST_DELAY_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> dac_code == '0); // R3
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && !$past(reg_we && reg_addr == 2'd1)) |-> $fell(go_q)); // R5
  AST_RESULT_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $fell(go_q)); // R5
  AST_SLEEP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && go_q && cks_q != 2'd3) |=> !go_q); // R7
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(sleep_req && wake_en)); // R8
endmodule

bind adc_sar_seq adc_sar_seq_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .sleep_req(sleep_req), .wake_en(wake_en), .en_q(en_q), .go_q(go_q),
  .irq_q(irq_q), .wake_q(wake_q), .cks_q(cks_q), .res_q(res_q),
  .dac_code(dac_code)
);

// File: tb/test_adc_sar_seq.sv
module test_adc_sar_seq;
  logic       clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, sleep_req = 1'b0, wake_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [3:0] chan_sel, port_cfg;
  logic [9:0] dac_code, vin = '0;
  logic       adc_pwr, wake_req, cmp_in;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  adc_sar_seq i_adc_sar_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .wake_en(wake_en), .cmp_in(cmp_in), .chan_sel(chan_sel), .port_cfg(port_cfg),
    .dac_code(dac_code), .adc_pwr(adc_pwr), .wake_req(wake_req)
  );

  // {clk select[2], align[1], channel[4], input level[10]}
  localparam logic [16:0] VEC [6] = '{
    {2'd0, 1'b1, 4'd3,  10'h3FF}, {2'd1, 1'b0, 4'd11, 10'h000},
    {2'd2, 1'b1, 4'd7,  10'h155}, {2'd3, 1'b0, 4'd0,  10'h2AA},
    {2'd0, 1'b0, 4'd5,  10'h201}, {2'd1, 1'b1, 4'd9,  10'h1FE}};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd0; #1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_addr = 2'd0; #1;
    while (reg_rdata[1] && n < 1000) begin @(negedge clk); n++; #1; end
  endtask

  function automatic logic [15:0] pair(input logic [9:0] v, input logic rj);
    return rj ? {6'b0, v} : {v, 6'b0};
  endfunction

  function automatic int period(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : (s == 2'd2) ? 32 : 4;
  endfunction

  task automatic result(output logic [15:0] p);
    logic [7:0] h, l;
    rd(2'd2, h); rd(2'd3, l); p = {h, l};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] p, prev;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 addr0", d, 0);
    rd(2'd1, d); chk("R1 addr1", d, 0);
    chk("R1 pwr", adc_pwr, 0);
    chk("R1 wake", wake_req, 0);

    wr(2'd0, 8'h02);
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk("R2 busy ignored", d[1], 0);
    chk("R2 pwr off", adc_pwr, 0);

    foreach (VEC[i]) begin
      logic [1:0] s = VEC[i][16:15];
      logic rj = VEC[i][14];
      logic [3:0] ch = VEC[i][13:10];
      vin = VEC[i][9:0];
      wr(2'd1, {rj, 1'b0, 2'b00, ch ^ 4'hA});
      wr(2'd0, {ch, s, 2'b11});
      chk("R3 delay code", dac_code, 0);
      chk("R11 chan", chan_sel, ch);
      chk("R11 cfg", port_cfg, ch ^ 4'hA);
      wait_idle(n);
      chk("R3 R6 length", n, 1 + 12 * period(s));
      rd(2'd1, d); chk("R5 done flag", d[6], 1);
      result(p); chk("R4 R9 result", p, pair(vin, rj));
      wr(2'd1, {rj, 1'b0, 2'b00, ch ^ 4'hA});
      rd(2'd1, d); chk("R5 flag clear", d[6], 0);
    end
    result(prev);

    vin = 10'h0AB;
    wr(2'd0, {4'd2, 2'd2, 2'b11});
    repeat (50) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk); #1;
    rd(2'd0, d); chk("R7 abort busy", d[1], 0);
    rd(2'd1, d); chk("R7 no flag", d[6], 0);
    result(p); chk("R7 result kept", p, prev);
    chk("R7 pwr", adc_pwr, 0);
    chk("R7 wake", wake_req, 0);
    sleep_req = 1'b0;

    wake_en = 1'b1; vin = 10'h0F3;
    wr(2'd0, {4'd1, 2'd3, 2'b11});
    repeat (5) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    chk("R8 pwr in sleep", adc_pwr, 1);
    wait_idle(n);
    rd(2'd1, d); chk("R8 done flag", d[6], 1);
    result(p); chk("R8 result", p, pair(vin, 1'b1));
    chk("R8 wake", wake_req, 1);
    sleep_req = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 wake clear", wake_req, 0);
    wr(2'd1, 8'h80);

    wake_en = 1'b0; vin = 10'h31C;
    wr(2'd0, {4'd1, 2'd3, 2'b11});
    repeat (5) @(negedge clk);
    sleep_req = 1'b1;
    wait_idle(n);
    result(p); chk("R8 result nowake", p, pair(vin, 1'b1));
    @(negedge clk);
    chk("R8 no wake", wake_req, 0);
    chk("R8 powered down", adc_pwr, 0);
    sleep_req = 1'b0;
    wr(2'd1, 8'h80);
    result(prev);

    vin = 10'h111;
    wr(2'd0, {4'd4, 2'd1, 2'b11});
    repeat (20) @(negedge clk);
    wr(2'd0, {4'd4, 2'd1, 2'b01});
    rd(2'd0, d); chk("R10 abort busy", d[1], 0);
    repeat (120) @(negedge clk);
    rd(2'd1, d); chk("R10 no flag", d[6], 0);
    result(p); chk("R10 result kept", p, prev);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule